// File: doc/BRIEF.md
# Parallel Port Transmit Handshake Engine

This block is the host end of a byte-wide, printer-style output port. Bytes arrive on a valid/ready stream. Each accepted byte goes onto an 8-bit data bus, and the block then issues an active-low data strobe. The time the byte sits on the bus before the strobe (the setup time) and the length of the strobe are configuration inputs, both counted in system clocks. The strobe length has a floor of three clocks. After each strobe there is a fixed three-clock gap before the next byte may be placed on the bus.

A two-bit mode input selects how transfers are paced. In busy-only pacing, the block looks at the peripheral's busy line just before it raises a strobe and again once the strobe has ended, and it ignores the acknowledge line. In acknowledge pacing, every byte needs one acknowledge pulse from the peripheral, and busy is still checked before each strobe and at the end of each byte. Both peripheral inputs are asynchronous and each passes through a two-flop synchroniser. The mode and timing fields are captured when a byte is accepted and hold for the whole of that byte.

Top module: `pptx_engine`

## Requirements
- R1: A byte is driven on `pData` at the clock edge that accepts it. `strobeN` falls exactly `cfgSetup` clocks after that edge when busy is low; a setup value of 0 makes the strobe fall on the same edge. `pData` stays constant while `strobeN` is low.
- R2: `strobeN` stays low for max(`cfgWidth`, 3) clocks. Any programmed value below 3 is treated as 3.
- R3: After `strobeN` rises, it stays high for at least 3 clocks. The next byte cannot be accepted until 3 clocks after the rise.
- R4: `cfgMode` values other than 2'b10 select busy-only pacing, in which `ackInN` has no effect. With setup 0, width 3, busy low and a steady input stream, a strobe falls every 6 clocks.
- R5: In both modes, `strobeN` never falls while the synchronised `busyIn` is high. A pending byte is strobed only after `busyIn` returns low.
- R6: In busy-only pacing, if `busyIn` is high when the post-strobe gap ends, `done` and `inReady` are withheld until `busyIn` goes low.
- R7: `cfgMode` = 2'b10 selects acknowledge pacing. Completion of a byte, and acceptance of the next, wait for a falling edge on `ackInN` that occurs after the strobe has fallen. One low pulse counts once.
- R8: In acknowledge pacing, if `busyIn` is high at the end of a byte, completion is held off until `busyIn` goes low, even after the acknowledge has arrived.
- R9: The mode and width fields are captured at acceptance. Changing them while a byte is in flight does not change that byte's strobe width or its pacing mode.
- R10: After reset, `strobeN`=1, `pData`=0, `inReady`=1 and `done`=0. `inReady` is high only when no byte is in flight. `done` is a single-clock pulse, raised once per completed byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input stream: byte valid |
| inData | input | 8 | Input stream: byte |
| inReady | output | 1 | Input stream: block can accept a byte |
| cfgSetup | input | 4 | Setup clocks before the strobe |
| cfgWidth | input | 4 | Strobe width in clocks (minimum 3) |
| cfgMode | input | 2 | 2'b10 = acknowledge pacing, other values = busy-only pacing |
| busyIn | input | 1 | Peripheral busy, active high, asynchronous |
| ackInN | input | 1 | Peripheral acknowledge, active low, asynchronous |
| pData | output | 8 | Parallel data bus |
| strobeN | output | 1 | Data strobe, active low |
| done | output | 1 | One-clock pulse when a byte completes |

## Verification
Every timing result is counted from the edge that accepts a byte:
- The strobe falls `cfgSetup` edges after acceptance.
- It rises a further max(`cfgWidth`,3) edges later.
- The next acceptance comes three edges after the rise.

The bench timestamps each acceptance and each strobe edge against a cycle counter, sampling on the falling clock edge. It then compares the differences exactly, so an off-by-one anywhere in the chain shows up.

Responses to `busyIn` and `ackInN` pass through two synchroniser flops before the control sees them. For these, the bench waits a fixed window after each pin change: a hold-off is checked well inside the window, and a release is checked only after at least six clocks have passed. A scoreboard queue pairs each accepted byte with the bus value seen at its strobe.

// File: rtl/pptx_pkg.sv
package pptx_pkg;

  localparam int MIN_WIDTH = 3;
  localparam int GAP_CLKS  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_GAP,
    ST_WAIT
  } pptxState_t;

  typedef struct packed {
    logic accept;
    logic loadSetup;
    logic loadWidth;
    logic loadGap;
    logic countDown;
  } pptxCtl_t;

endpackage

// File: rtl/pptx_sync.sv
module pptx_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RESET_VAL;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RESET_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pptx_datapath.sv
module pptx_datapath
  import pptx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pptxCtl_t          ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [TIME_W-1:0] cfgSetup,
  input  logic [TIME_W-1:0] cfgWidth,
  input  logic [1:0]        cfgMode,
  output logic [DATA_W-1:0] pData,
  output logic              cntZero,
  output logic              cntLast,
  output logic              setupZeroIn,
  output logic              ackModeQ
);

  localparam logic [TIME_W-1:0] MIN_W   = TIME_W'(MIN_WIDTH);
  localparam logic [TIME_W-1:0] GAP_LD  = TIME_W'(GAP_CLKS - 2);
  localparam logic [TIME_W-1:0] ONE     = TIME_W'(1);

  logic [DATA_W-1:0] dataQ;
  logic [TIME_W-1:0] widthQ;
  logic [TIME_W-1:0] cntQ;
  logic [TIME_W-1:0] widthEffIn;
  logic [TIME_W-1:0] widthSel;

  function automatic logic [TIME_W-1:0] clampWidth(input logic [TIME_W-1:0] w);
    return (w < MIN_W) ? MIN_W : w;
  endfunction

  assign widthEffIn  = clampWidth(cfgWidth);
  assign widthSel    = ctl.accept ? widthEffIn : widthQ;
  assign setupZeroIn = (cfgSetup == '0);

  // Byte and per-byte configuration, captured at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ    <= '0;
      widthQ   <= MIN_W;
      ackModeQ <= 1'b0;
    end else if (ctl.accept) begin
      dataQ    <= inData;
      widthQ   <= widthEffIn;
      ackModeQ <= (cfgMode == 2'b10);
    end
  end

  // One shared down-counter serves setup, strobe width and gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.loadSetup) begin
      cntQ <= cfgSetup;
    end else if (ctl.loadWidth) begin
      cntQ <= widthSel - ONE;
    end else if (ctl.loadGap) begin
      cntQ <= GAP_LD;
    end else if (ctl.countDown && (cntQ != '0)) begin
      cntQ <= cntQ - ONE;
    end
  end

  assign cntZero = (cntQ == '0);
  assign cntLast = (cntQ <= ONE);
  assign pData   = dataQ;

  AST_WIDTH_NOT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWidth |=> (cntQ >= TIME_W'(MIN_WIDTH - 1))); // R2

endmodule

// File: rtl/pptx_ctrl.sv
module pptx_ctrl
  import pptx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     busyS,
  input  logic     ackNS,
  input  logic     cntZero,
  input  logic     cntLast,
  input  logic     setupZeroIn,
  input  logic     ackModeQ,
  output pptxCtl_t ctl,
  output logic     inReady,
  output logic     strobeN,
  output logic     done
);

  pptxState_t stateQ, stateD;
  logic strobeNQ;
  logic doneQ, doneD;
  logic ackPrevQ;
  logic ackFall;
  logic ackSeenQ;
  logic release_;

  assign ackFall  = ackPrevQ & ~ackNS;
  assign release_ = !busyS && (!ackModeQ || ackSeenQ);

  always_comb begin
    stateD  = stateQ;
    ctl     = '0;
    doneD   = 1'b0;
    inReady = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.accept = 1'b1;
          if (setupZeroIn && !busyS) begin
            ctl.loadWidth = 1'b1;
            stateD        = ST_STROBE;
          end else begin
            ctl.loadSetup = 1'b1;
            stateD        = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (cntLast && !busyS) begin
          ctl.loadWidth = 1'b1;
          stateD        = ST_STROBE;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cntZero) begin
          ctl.loadGap = 1'b1;
          stateD      = ST_GAP;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_GAP: begin
        if (cntZero) begin
          if (release_) begin
            doneD  = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stateD = ST_WAIT;
          end
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_WAIT: begin
        if (release_) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      strobeNQ <= 1'b1;
      doneQ    <= 1'b0;
      ackPrevQ <= 1'b1;
    end else begin
      stateQ   <= stateD;
      strobeNQ <= (stateD != ST_STROBE);
      doneQ    <= doneD;
      ackPrevQ <= ackNS;
    end
  end

  // Acknowledge is latched once per byte, counted only after the strobe starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSeenQ <= 1'b0;
    end else if (ctl.accept) begin
      ackSeenQ <= 1'b0;
    end else if (ackFall && (stateQ == ST_STROBE || stateQ == ST_GAP || stateQ == ST_WAIT)) begin
      ackSeenQ <= 1'b1;
    end
  end

  assign strobeN = strobeNQ;
  assign done    = doneQ;

  AST_STROBE_MIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeNQ) |-> !strobeNQ ##1 !strobeNQ ##1 !strobeNQ); // R2

  AST_GAP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeNQ) |-> strobeNQ ##1 strobeNQ ##1 strobeNQ); // R3

  AST_NO_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeNQ) |-> !$past(busyS)); // R5

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !$past(busyS)); // R6 R8

  AST_ACK_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && ackModeQ) |-> $past(ackSeenQ)); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> strobeNQ); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R10

endmodule

// File: rtl/pptx_engine.sv
module pptx_engine
  import pptx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  input  logic [TIME_W-1:0] cfgSetup,
  input  logic [TIME_W-1:0] cfgWidth,
  input  logic [1:0]        cfgMode,
  input  logic              busyIn,
  input  logic              ackInN,
  output logic [DATA_W-1:0] pData,
  output logic              strobeN,
  output logic              done
);

  pptxCtl_t ctl;
  logic [1:0] syncOut;
  logic busyS, ackNS;
  logic cntZero, cntLast, setupZeroIn, ackModeQ;

  pptx_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(2'b10)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({ackInN, busyIn}),
    .syncOut(syncOut)
  );

  assign busyS = syncOut[0];
  assign ackNS = syncOut[1];

  pptx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .busyS      (busyS),
    .ackNS      (ackNS),
    .cntZero    (cntZero),
    .cntLast    (cntLast),
    .setupZeroIn(setupZeroIn),
    .ackModeQ   (ackModeQ),
    .ctl        (ctl),
    .inReady    (inReady),
    .strobeN    (strobeN),
    .done       (done)
  );

  pptx_datapath #(
    .DATA_W(DATA_W),
    .TIME_W(TIME_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .inData     (inData),
    .cfgSetup   (cfgSetup),
    .cfgWidth   (cfgWidth),
    .cfgMode    (cfgMode),
    .pData      (pData),
    .cntZero    (cntZero),
    .cntLast    (cntLast),
    .setupZeroIn(setupZeroIn),
    .ackModeQ   (ackModeQ)
  );

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeN && $past(!strobeN)) |-> $stable(pData)); // R1

endmodule

// File: tb/sim_pptx_engine.sv
`timescale 1ns/1ps
module sim_pptx_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady;
  logic [3:0] cfgSetup = '0;
  logic [3:0] cfgWidth = 4'd3;
  logic [1:0] cfgMode = 2'b01;
  logic       busyIn = 1'b0;
  logic       ackInN = 1'b1;
  logic [7:0] pData;
  logic       strobeN;
  logic       done;

  always #10 clk = ~clk;

  pptx_engine u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .cfgSetup(cfgSetup), .cfgWidth(cfgWidth), .cfgMode(cfgMode),
    .busyIn(busyIn), .ackInN(ackInN), .pData(pData), .strobeN(strobeN), .done(done)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int acceptCyc = 0;
  int fallCyc = 0;
  int riseCyc = 0;
  int periodMeas = 0;
  int widthMeas = 0;
  int setupMeas = 0;
  int nStrobes = 0;
  int nDone = 0;
  bit autoAck = 1'b0;
  bit strobePrev = 1'b1;
  bit donePrev = 1'b0;
  logic [7:0] expQ[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
    end
  end

  // Monitor: scoreboard pops at each strobe fall, timestamps edges
  always @(negedge clk) begin
    if (rstN) begin
      if (strobePrev && !strobeN) begin
        periodMeas = cyc - fallCyc;
        fallCyc = cyc;
        setupMeas = cyc - acceptCyc;
        nStrobes++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R1 unexpected strobe", 0, 1);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(pData == e, "R1 data at strobe", pData, e);
        end
      end
      if (!strobePrev && strobeN) begin
        widthMeas = cyc - fallCyc;
        riseCyc = cyc;
      end
      if (done) begin
        nDone++;
        if (donePrev) chk(1'b0, "R10 done longer than one clock", 2, 1);
      end
      strobePrev = strobeN;
      donePrev = done;
    end
  end

  // Peripheral acknowledge responder
  initial forever begin
    @(negedge strobeN);
    if (autoAck) begin
      repeat (3) @(negedge clk);
      ackInN = 1'b0;
      repeat (2) @(negedge clk);
      ackInN = 1'b1;
    end
  end

  // Driver: pushes expected byte, holds valid until accepted
  task automatic sendByte(input logic [7:0] b);
    inValid = 1'b1;
    inData = b;
    expQ.push_back(b);
    while (!inReady) @(negedge clk);
    acceptCyc = cyc + 1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic ackPulse();
    ackInN = 1'b0;
    repeat (2) @(negedge clk);
    ackInN = 1'b1;
  endtask

  initial begin
    int d0, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(strobeN == 1'b1, "R10 reset strobeN", strobeN, 1);
    chk(pData == 8'h00, "R10 reset pData", pData, 0);
    chk(inReady == 1'b1, "R10 reset inReady", inReady, 1);
    chk(done == 1'b0, "R10 reset done", done, 0);

    // R4 busy-only stream, ack pulses present but ignored
    cfgMode = 2'b01; cfgSetup = 0; cfgWidth = 3; autoAck = 1'b1;
    d0 = nDone;
    sendByte(8'hA5); sendByte(8'h3C); sendByte(8'hF0); sendByte(8'h0F);
    repeat (12) @(negedge clk);
    chk(periodMeas == 6, "R4 strobe period", periodMeas, 6);
    chk(setupMeas == 0, "R1 zero setup", setupMeas, 0);
    chk(widthMeas == 3, "R2 width 3", widthMeas, 3);
    chk(nDone - d0 == 4, "R10 one done per byte", nDone - d0, 4);

    // R2 width clamp and long width
    cfgWidth = 1; sendByte(8'h11); repeat (10) @(negedge clk);
    chk(widthMeas == 3, "R2 width 1 clamped", widthMeas, 3);
    cfgWidth = 0; sendByte(8'h22); repeat (10) @(negedge clk);
    chk(widthMeas == 3, "R2 width 0 clamped", widthMeas, 3);
    cfgWidth = 7; sendByte(8'h33); repeat (14) @(negedge clk);
    chk(widthMeas == 7, "R2 width 7", widthMeas, 7);

    // R1 setup time, R3 gap to next acceptance
    cfgWidth = 3; cfgSetup = 4;
    sendByte(8'h44);
    sendByte(8'h55);
    chk(acceptCyc - riseCyc == 3, "R3 rise to next accept", acceptCyc - riseCyc, 3);
    repeat (12) @(negedge clk);
    chk(setupMeas == 4, "R1 setup 4", setupMeas, 4);
    cfgSetup = 0;

    // R5 busy held before strobe
    busyIn = 1'b1; repeat (4) @(negedge clk);
    s0 = nStrobes;
    sendByte(8'h66);
    repeat (20) @(negedge clk);
    chk(nStrobes == s0, "R5 no strobe while busy", nStrobes - s0, 0);
    busyIn = 1'b0;
    repeat (8) @(negedge clk);
    chk(nStrobes == s0 + 1, "R5 strobe after busy clears", nStrobes - s0, 1);
    repeat (8) @(negedge clk);

    // R6 busy after strobe in busy-only pacing
    s0 = nStrobes; d0 = nDone;
    sendByte(8'h77);
    wait (nStrobes == s0 + 1);
    @(negedge clk); busyIn = 1'b1;
    repeat (15) @(negedge clk);
    chk(nDone == d0, "R6 done withheld while busy", nDone - d0, 0);
    chk(inReady == 1'b0, "R6 ready withheld while busy", inReady, 0);
    busyIn = 1'b0;
    repeat (6) @(negedge clk);
    chk(nDone == d0 + 1, "R6 done after busy clears", nDone - d0, 1);
    chk(inReady == 1'b1, "R6 ready after busy clears", inReady, 1);

    // R7 acknowledge pacing
    cfgMode = 2'b10; autoAck = 1'b0;
    d0 = nDone;
    sendByte(8'h88);
    repeat (20) @(negedge clk);
    chk(nDone == d0, "R7 no done without ack", nDone - d0, 0);
    chk(inReady == 1'b0, "R7 no ready without ack", inReady, 0);
    ackPulse();
    repeat (8) @(negedge clk);
    chk(nDone == d0 + 1, "R7 done after ack", nDone - d0, 1);
    ackPulse();
    repeat (8) @(negedge clk);
    chk(nDone == d0 + 1, "R7 stray ack no effect", nDone - d0, 1);
    autoAck = 1'b1;
    sendByte(8'h99); sendByte(8'hAA); sendByte(8'hBB);
    repeat (30) @(negedge clk);
    chk(nDone == d0 + 4, "R7 ack-paced stream", nDone - d0, 4);

    // R8 busy at end of byte in acknowledge pacing
    s0 = nStrobes; d0 = nDone;
    sendByte(8'hCC);
    wait (nStrobes == s0 + 1);
    @(negedge clk); busyIn = 1'b1;
    repeat (20) @(negedge clk);
    chk(nDone == d0, "R8 done held by busy", nDone - d0, 0);
    busyIn = 1'b0;
    repeat (8) @(negedge clk);
    chk(nDone == d0 + 1, "R8 done after busy clears", nDone - d0, 1);

    // R9 configuration captured at acceptance
    cfgMode = 2'b01; cfgWidth = 6; autoAck = 1'b0;
    sendByte(8'hDD);
    cfgWidth = 3;
    repeat (14) @(negedge clk);
    chk(widthMeas == 6, "R9 width held", widthMeas, 6);
    cfgMode = 2'b10; d0 = nDone;
    sendByte(8'hEE);
    cfgMode = 2'b01;
    repeat (20) @(negedge clk);
    chk(nDone == d0, "R9 ack mode held", nDone - d0, 0);
    ackPulse();
    repeat (8) @(negedge clk);
    chk(nDone == d0 + 1, "R9 done after ack", nDone - d0, 1);
    chk(expQ.size() == 0, "R1 all bytes strobed", expQ.size(), 0);

    report();
  end

endmodule